// File: doc/BRIEF.md
# Program Counter and Next-Address Unit

This block owns the program counter of a processor that finishes each instruction in one clock cycle. The counter value is driven straight out as the instruction address. The external instruction store returns the fetched word on the same cycle, with no register in between. From that word the block takes two fields: a 16-bit signed displacement in bits 15:0 and a 26-bit jump field in bits 25:0. It then chooses the next counter value from three candidates:

- the following word, which is the counter plus 4;
- a displacement-relative branch destination;
- a region-local jump destination. This keeps the top four counter bits and replaces the rest with the jump field followed by two zeros.

Decode logic elsewhere supplies two flags: one that marks the current instruction as a conditional branch, and one that marks it as a jump. The ALU supplies its equality (zero) result. The block itself decides whether a branch is taken, by combining the branch flag with the zero result. The jump choice overrides everything else.

The choice is expressed as a named source selection with three values:

- `SRC_SEQ` is the plain step to the next word.
- `SRC_TAKEN` is a taken branch.
- `SRC_JUMP` is a jump.

There is one transition per cycle, into whichever source the current flags pick. The only state the block holds is the counter register. A synchronous, active-high reset loads it with a parameterised start address.

Top module: `pc_fetch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the counter loads `RESET_VEC` (default 0x0000_0000), and `instr_addr_o` shows that value after the edge.
- R2: With `is_branch_i` and `is_jump_i` both low, the next counter value is the current value plus 4 (source `SRC_SEQ`).
- R3: With `is_branch_i` high, `alu_zero_i` low and `is_jump_i` low, the next counter value is the current value plus 4.
- R4: With `is_branch_i` and `alu_zero_i` both high and `is_jump_i` low, the next counter value is: current value + 4 + (sign-extended `instr_i[15:0]` shifted left by two). The sum wraps modulo 2^32 (source `SRC_TAKEN`).
- R5: A displacement with bit 15 set moves the counter backwards. A displacement of 0xFFFF from any address A yields A.
- R6: With `is_jump_i` high, the next counter value is the concatenation {current[31:28], `instr_i[25:0]`, 2'b00} (source `SRC_JUMP`).
- R7: A jump takes priority over a taken branch when `is_jump_i`, `is_branch_i` and `alu_zero_i` are all high.
- R8: `alu_zero_i` high without `is_branch_i` has no effect: the counter still advances by 4.
- R9: `instr_addr_o` equals the counter register. It changes only at rising clock edges, exactly one edge after the controls that select it.
- R10: Starting from a word-aligned `RESET_VEC`, bits 1:0 of `instr_addr_o` stay 00 in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to `RESET_VEC` |
| is_branch_i | input | 1 | Current instruction is a conditional branch |
| alu_zero_i | input | 1 | Equality result from the ALU |
| is_jump_i | input | 1 | Current instruction is a jump |
| instr_i | input | 32 | Instruction word fetched from `instr_addr_o` |
| instr_addr_o | output | 32 | Current program counter, used as the fetch address |

## Verification
Every counter result is due exactly one rising edge after the flags and instruction word that select it. A reset result is likewise due one edge after `rst` is sampled high. The bench changes inputs only at falling edges and computes the expected counter at that moment, from the address it sees and the word it supplies. It compares at the next falling edge, so each comparison falls exactly one register stage after its stimulus. The bench uses a reset vector different from zero, so that the value a reset produces cannot be confused with a natural count.

// File: rtl/pc_fetch_pkg.sv
package pc_fetch_pkg;

    // Source of the next program-counter value
    typedef enum logic [1:0] {
        SRC_SEQ   = 2'd0,
        SRC_TAKEN = 2'd1,
        SRC_JUMP  = 2'd2
    } pc_src_e;

    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned ALIGN_BITS = 2;

endpackage

// File: rtl/pc_target_gen.sv
module pc_target_gen #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IMM_W  = 16,
    parameter int unsigned TGT_W  = 26
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [IMM_W-1:0]  disp_i,
    input  logic [TGT_W-1:0]  jfield_i,
    output logic [ADDR_W-1:0] seq_o,
    output logic [ADDR_W-1:0] taken_o,
    output logic [ADDR_W-1:0] jump_o
);
    import pc_fetch_pkg::*;

    localparam int unsigned EXT_W = ADDR_W - IMM_W - ALIGN_BITS;
    localparam int unsigned HI_W  = ADDR_W - TGT_W - ALIGN_BITS;

    logic [ADDR_W-1:0] disp_scaled;

    // Sign-extend the displacement and scale words to bytes
    assign disp_scaled = {{EXT_W{disp_i[IMM_W-1]}}, disp_i, {ALIGN_BITS{1'b0}}};

    assign seq_o   = pc_i + ADDR_W'(WORD_BYTES);
    assign taken_o = seq_o + disp_scaled;
    // Region-local jump keeps the upper counter bits
    assign jump_o  = {pc_i[ADDR_W-1 -: HI_W], jfield_i, {ALIGN_BITS{1'b0}}};

endmodule

// File: rtl/pc_src_sel.sv
module pc_src_sel (
    input  logic                  is_branch_i,
    input  logic                  alu_zero_i,
    input  logic                  is_jump_i,
    output pc_fetch_pkg::pc_src_e src_o
);
    import pc_fetch_pkg::*;

    logic take_branch;

    // Taken only when the decoded branch flag meets an equal result
    assign take_branch = is_branch_i & alu_zero_i;

    always_comb begin
        unique case ({is_jump_i, take_branch})
            2'b00:   src_o = SRC_SEQ;
            2'b01:   src_o = SRC_TAKEN;
            default: src_o = SRC_JUMP;   // jump overrides branch
        endcase
    end

endmodule

// File: rtl/pc_reg.sv
module pc_reg #(
    parameter int unsigned      ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] pc_next_i,
    output logic [ADDR_W-1:0] pc_o
);
    logic [ADDR_W-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_VEC;
        else     pc_q <= pc_next_i;
    end

    assign pc_o = pc_q;

    // R1: reset loads the start address on the following edge
    assert_reset_load_R1: assert property (@(posedge clk)
        rst |=> (pc_q == RESET_VEC));

    // R9: the counter only follows the selected next value
    assert_follows_next_R9: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (pc_q == $past(pc_next_i)));

endmodule

// File: rtl/pc_fetch_unit.sv
module pc_fetch_unit #(
    parameter int unsigned      ADDR_W    = 32,
    parameter int unsigned      INSTR_W   = 32,
    parameter int unsigned      IMM_W     = 16,
    parameter int unsigned      TGT_W     = 26,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               is_branch_i,
    input  logic               alu_zero_i,
    input  logic               is_jump_i,
    input  logic [INSTR_W-1:0] instr_i,
    output logic [ADDR_W-1:0]  instr_addr_o
);
    import pc_fetch_pkg::*;

    localparam int unsigned EXT_W = ADDR_W - IMM_W - ALIGN_BITS;
    localparam int unsigned HI_W  = ADDR_W - TGT_W - ALIGN_BITS;

    logic [ADDR_W-1:0] pc_cur;
    logic [ADDR_W-1:0] pc_next;
    logic [ADDR_W-1:0] cand_seq;
    logic [ADDR_W-1:0] cand_taken;
    logic [ADDR_W-1:0] cand_jump;
    logic [IMM_W-1:0]  disp_field;
    logic [TGT_W-1:0]  jump_field;
    pc_src_e           src_sel;
    logic              unused_op_bits;

    // Field extraction from the fetched word
    assign disp_field     = instr_i[IMM_W-1:0];
    assign jump_field     = instr_i[TGT_W-1:0];
    assign unused_op_bits = ^instr_i[INSTR_W-1:TGT_W];

    pc_target_gen #(
        .ADDR_W (ADDR_W),
        .IMM_W  (IMM_W),
        .TGT_W  (TGT_W)
    ) u_targets (
        .pc_i     (pc_cur),
        .disp_i   (disp_field),
        .jfield_i (jump_field),
        .seq_o    (cand_seq),
        .taken_o  (cand_taken),
        .jump_o   (cand_jump)
    );

    pc_src_sel u_sel (
        .is_branch_i (is_branch_i),
        .alu_zero_i  (alu_zero_i),
        .is_jump_i   (is_jump_i),
        .src_o       (src_sel)
    );

    // Next-value selection, one branch per source
    always_comb begin
        unique case (src_sel)
            SRC_TAKEN: pc_next = cand_taken;
            SRC_JUMP:  pc_next = cand_jump;
            default:   pc_next = cand_seq;
        endcase
    end

    pc_reg #(
        .ADDR_W    (ADDR_W),
        .RESET_VEC (RESET_VEC)
    ) u_pc (
        .clk       (clk),
        .rst       (rst),
        .pc_next_i (pc_next),
        .pc_o      (pc_cur)
    );

    assign instr_addr_o = pc_cur;

    // R2, R3, R8: any non-jump, non-taken cycle steps one word
    assert_step_word_R2: assert property (@(posedge clk) disable iff (rst)
        (!is_jump_i && !(is_branch_i && alu_zero_i))
        |=> (instr_addr_o == $past(instr_addr_o) + ADDR_W'(WORD_BYTES)));

    // R4: taken branch adds the scaled signed displacement
    assert_taken_branch_R4: assert property (@(posedge clk) disable iff (rst)
        (!is_jump_i && is_branch_i && alu_zero_i)
        |=> (instr_addr_o == $past(instr_addr_o) + ADDR_W'(WORD_BYTES)
             + {{EXT_W{$past(instr_i[IMM_W-1])}}, $past(instr_i[IMM_W-1:0]), 2'b00}));

    // R6, R7: jump wins regardless of branch inputs
    assert_jump_dest_R6: assert property (@(posedge clk) disable iff (rst)
        is_jump_i
        |=> (instr_addr_o == {$past(instr_addr_o[ADDR_W-1 -: HI_W]),
                              $past(instr_i[TGT_W-1:0]), 2'b00}));

    // R10: word alignment is kept once out of reset
    assert_aligned_R10: assert property (@(posedge clk) disable iff (rst)
        (instr_addr_o[ALIGN_BITS-1:0] == '0));

endmodule

// File: tb/pc_fetch_unit_tb.sv
module pc_fetch_unit_tb;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] RST_VEC    = 32'h0000_0100;
    localparam int          MEM_WORDS  = 64;
    localparam int          RAND_STEPS = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        is_branch = 1'b0;
    logic        alu_zero  = 1'b0;
    logic        is_jump   = 1'b0;
    logic [31:0] instr_drv = '0;
    logic [31:0] instr_addr;

    logic [31:0] imem [MEM_WORDS];

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_fetch_unit #(.RESET_VEC(RST_VEC)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .is_branch_i  (is_branch),
        .alu_zero_i   (alu_zero),
        .is_jump_i    (is_jump),
        .instr_i      (instr_drv),
        .instr_addr_o (instr_addr)
    );

    function automatic logic [31:0] ref_next(input logic [31:0] pc, input logic [31:0] w,
                                             input logic br, input logic z, input logic j);
        if (j)       return {pc[31:28], w[25:0], 2'b00};
        if (br && z) return pc + 32'd4 + {{14{w[15]}}, w[15:0], 2'b00};
        return pc + 32'd4;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge; checks at the next falling edge
    task automatic step(input string req, input logic br, input logic z, input logic j,
                        input logic [31:0] w);
        logic [31:0] exp;
        is_branch = br; alu_zero = z; is_jump = j; instr_drv = w;
        exp = ref_next(instr_addr, w, br, z, j);
        @(negedge clk);
        check(req, instr_addr, exp);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", instr_addr, RST_VEC);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (RAND_STEPS + 200) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEM_WORDS; i++) imem[i] = $urandom;

        @(negedge clk);
        do_reset();                                      // R1

        // R9: address holds the current counter before the edge
        check("R9", instr_addr, RST_VEC);
        step("R2", 1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF);    // R2 plain step
        step("R8", 1'b0, 1'b1, 1'b0, 32'h0000_7FFF);    // R8 zero alone
        step("R3", 1'b1, 1'b0, 1'b0, 32'h0000_0010);    // R3 not taken
        step("R4", 1'b1, 1'b1, 1'b0, 32'h0000_0010);    // R4 forward
        step("R5", 1'b1, 1'b1, 1'b0, 32'h0000_FFFF);    // R5 -1 word: back to self
        step("R5", 1'b1, 1'b1, 1'b0, 32'h0000_FFF0);    // R5 backward
        step("R6", 1'b0, 1'b0, 1'b1, 32'hFC00_0040);    // R6 jump
        step("R7", 1'b1, 1'b1, 1'b1, 32'h0000_0400);    // R7 jump over branch
        step("R6", 1'b0, 1'b0, 1'b1, 32'h0000_0000);    // R6 jump to 0
        step("R4", 1'b1, 1'b1, 1'b0, 32'h0000_FFFE);    // R4 wrap below zero
        check("R4", instr_addr, 32'hFFFF_FFFC);
        step("R6", 1'b0, 1'b0, 1'b1, 32'h03FF_FFFF);    // R6 keeps top bits F
        check("R6", instr_addr, 32'hFFFF_FFFC);
        step("R2", 1'b0, 1'b0, 1'b0, 32'h1234_5678);    // R2 wrap to zero
        check("R2", instr_addr, 32'h0000_0000);

        // R9: inputs changed mid-cycle do not move the address before an edge
        is_jump = 1'b1; instr_drv = 32'h0000_0ABC;
        #(CLK_PERIOD/4);
        check("R9", instr_addr, 32'h0000_0000);
        @(negedge clk);
        check("R9", instr_addr, 32'h0000_2AF0);

        // Random mix with the array as instruction store
        for (int k = 0; k < RAND_STEPS; k++) begin
            logic br, z, j;
            logic [31:0] w;
            int sel;
            string tag;
            sel = int'($urandom_range(0, 9));
            br  = (sel >= 4);
            z   = $urandom_range(0, 1) == 1;
            j   = (sel == 9);
            w   = imem[instr_addr[7:2]];
            if (j)            tag = "R6";
            else if (br && z) tag = w[15] ? "R5" : "R4";
            else if (br)      tag = "R3";
            else              tag = z ? "R8" : "R2";
            if (k == RAND_STEPS / 2) begin
                do_reset();                              // R1 mid-run
            end else begin
                step(tag, br, z, j, w);
            end
            check("R10", {30'd0, instr_addr[1:0]}, 32'd0);
        end

        finish_run();
    end

endmodule